// File: doc/BRIEF.md
# Procedure Call Frame Sequencer

This block keeps the three pointer registers of a small stack machine: the instruction pointer, the stack pointer and the frame pointer. It carries out four procedure linkage commands against a single-port word memory. Those commands are call, frame entry, frame exit and return. A caller presents one command with its operands. The block then runs through a fixed series of memory pushes, memory pops and register copies, and it raises a one-cycle completion pulse once the registers hold their final values.

The stack grows toward lower addresses. A push first lowers the stack pointer by one word and then writes at the new address. A pop reads at the current stack pointer and raises it by one word. Read data returns one cycle after the read request. A call saves the instruction pointer. Frame entry saves the frame pointer, links a new frame and reserves local words, so a call followed by frame entry performs the whole four-step frame setup. Frame exit and return undo the two halves in reverse order.

Commands are plain control pins. The block takes a command on a clock edge where `cmd_valid` is high and `busy` is low. It drops any command offered while `busy` is high, without storing it. There is no back-pressure: the caller must wait for `done` before it offers the next command.

Top module: `frame_seq`

## Requirements
- R1: After reset, `ip_o`, `sp_o` and `fp_o` equal the parameters IP_INIT, SP_INIT and FP_INIT. At the same time `busy`, `done` and `mem_en` are all low.
- R2: Call (`cmd_op` = 2'd0) writes the current IP to address SP-1, lowers SP by one and loads `cmd_target` into IP. `done` is high two clock edges after the command is offered, counting the accepting edge.
- R3: Frame entry (`cmd_op` = 2'd1) writes FP to address SP-1 and lowers SP by one. It then copies SP into FP and subtracts the local size from SP. `done` comes three edges after the command is offered.
- R4: The local size `cmd_locals` is an unsigned 16-bit word count that is zero-extended before the subtraction. A size of 0 leaves SP equal to the new FP, and 16'hFFFF subtracts 65535 modulo 2^32.
- R5: Frame exit (`cmd_op` = 2'd2) copies FP into SP. It then pops the word at that address into FP and leaves SP one above the old FP. `done` comes four edges after the command is offered.
- R6: Return (`cmd_op` = 2'd3) pops the word at SP into IP and raises SP by one. `done` comes three edges after the command is offered.
- R7: Every memory write is a push to SP-1, followed by SP one lower on the next cycle. Every read is at SP, followed by SP one higher. There is at most one access per cycle.
- R8: A command offered while `busy` is high is ignored. It causes no memory write and no register change beyond those of the command already running.
- R9: `done` is a single-cycle pulse. `busy` is low while `done` is high, and the registers then hold their final values. While the block is idle with no command, nothing changes.
- R10: A call followed by frame entry leaves the return point at the old SP-1 and the saved FP at the old SP-2, in that write order.
- R11: Call, frame entry, frame exit and return in sequence restore SP and FP to their starting values and load IP with the IP saved by the call.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_op | input | 2 | 0 call, 1 frame entry, 2 frame exit, 3 return |
| cmd_target | input | 32 | Entry address for call |
| cmd_locals | input | 16 | Local words to reserve on frame entry |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse: registers final |
| ip_o | output | 32 | Instruction pointer |
| sp_o | output | 32 | Stack pointer |
| fp_o | output | 32 | Frame pointer |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |

## Verification
The latency of each command is fixed: two edges for call, three for frame entry and return, and four for frame exit, counted from the edge that accepts the command. The bench drives each command on a falling edge and counts rising edges until it sees `done` at a falling edge. It then compares that count with the fixed figure and checks the registers in that same cycle. Memory effects are checked on the bench's memory model, whose read data lags the request by one edge. Each write's address, data and order are logged between command acceptance and `done`.

// File: rtl/fs_pkg.sv
package fs_pkg;
  typedef enum logic [1:0] {
    OP_CALL  = 2'd0,
    OP_ENTER = 2'd1,
    OP_LEAVE = 2'd2,
    OP_RET   = 2'd3
  } fs_op_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PUSH_IP = 3'd1,
    ST_PUSH_FP = 3'd2,
    ST_LINK    = 3'd3,
    ST_UNLINK  = 3'd4,
    ST_POP_REQ = 3'd5,
    ST_POP_CAP = 3'd6
  } fs_step_e;
endpackage

// File: rtl/fs_ctrl.sv
module fs_ctrl
  import fs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cmd_valid,
  input  logic [1:0] cmd_op,
  output fs_step_e step,
  output logic     accept,
  output logic     pop_to_ip,
  output logic     busy,
  output logic     done
);
  fs_step_e step_q, step_d;
  logic     pop_ip_q, pop_ip_d;
  logic     done_q, done_d;

  assign accept = cmd_valid && (step_q == ST_IDLE);

  always_comb begin
    step_d   = step_q;
    pop_ip_d = pop_ip_q;
    done_d   = 1'b0;
    unique case (step_q)
      ST_IDLE: if (accept) begin
        unique case (fs_op_e'(cmd_op))
          OP_CALL:  step_d = ST_PUSH_IP;
          OP_ENTER: step_d = ST_PUSH_FP;
          OP_LEAVE: begin step_d = ST_UNLINK;  pop_ip_d = 1'b0; end
          OP_RET:   begin step_d = ST_POP_REQ; pop_ip_d = 1'b1; end
        endcase
      end
      ST_PUSH_IP: begin step_d = ST_IDLE; done_d = 1'b1; end
      ST_PUSH_FP: step_d = ST_LINK;
      ST_LINK:    begin step_d = ST_IDLE; done_d = 1'b1; end
      ST_UNLINK:  step_d = ST_POP_REQ;
      ST_POP_REQ: step_d = ST_POP_CAP;
      ST_POP_CAP: begin step_d = ST_IDLE; done_d = 1'b1; end
      default:    step_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q   <= ST_IDLE;
      pop_ip_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      step_q   <= step_d;
      pop_ip_q <= pop_ip_d;
      done_q   <= done_d;
    end
  end

  assign step      = step_q;
  assign pop_to_ip = pop_ip_q;
  assign busy      = (step_q != ST_IDLE);
  assign done      = done_q;
endmodule

// File: rtl/fs_regs.sv
module fs_regs
  import fs_pkg::*;
#(
  parameter int          W       = 32,
  parameter int          LW      = 16,
  parameter logic [W-1:0] IP_INIT = '0,
  parameter logic [W-1:0] SP_INIT = '0,
  parameter logic [W-1:0] FP_INIT = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  fs_step_e      step,
  input  logic          accept,
  input  logic          pop_to_ip,
  input  logic [W-1:0]  cmd_target,
  input  logic [LW-1:0] cmd_locals,
  input  logic [W-1:0]  mem_rdata,
  output logic [W-1:0]  ip,
  output logic [W-1:0]  sp,
  output logic [W-1:0]  fp,
  output logic          mem_en,
  output logic          mem_we,
  output logic [W-1:0]  mem_addr,
  output logic [W-1:0]  mem_wdata
);
  localparam int PADW = W - LW;

  logic [W-1:0]  tgt_q;
  logic [LW-1:0] loc_q;
  logic [W-1:0]  loc_ext;
  logic [W-1:0]  sp_dn;
  logic          is_push;

  generate
    if (PADW > 0) begin : g_pad
      assign loc_ext = {{PADW{1'b0}}, loc_q};
    end else begin : g_nopad
      assign loc_ext = loc_q[W-1:0];
    end
  endgenerate

  assign sp_dn     = sp - {{(W-1){1'b0}}, 1'b1};
  assign is_push   = (step == ST_PUSH_IP) || (step == ST_PUSH_FP);
  assign mem_en    = is_push || (step == ST_POP_REQ);
  assign mem_we    = is_push;
  assign mem_addr  = is_push ? sp_dn : sp;
  assign mem_wdata = (step == ST_PUSH_IP) ? ip : fp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= '0;
      loc_q <= '0;
    end else if (accept) begin
      tgt_q <= cmd_target;
      loc_q <= cmd_locals;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ip <= IP_INIT;
      sp <= SP_INIT;
      fp <= FP_INIT;
    end else begin
      unique case (step)
        ST_PUSH_IP: begin sp <= sp_dn; ip <= tgt_q; end
        ST_PUSH_FP: sp <= sp_dn;
        ST_LINK:    begin fp <= sp; sp <= sp - loc_ext; end
        ST_UNLINK:  sp <= fp;
        ST_POP_REQ: sp <= sp + {{(W-1){1'b0}}, 1'b1};
        ST_POP_CAP: if (pop_to_ip) ip <= mem_rdata; else fp <= mem_rdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/frame_seq.sv
module frame_seq
  import fs_pkg::*;
#(
  parameter int          W       = 32,
  parameter int          LW      = 16,
  parameter logic [W-1:0] IP_INIT = 32'h0000_1000,
  parameter logic [W-1:0] SP_INIT = 32'd200,
  parameter logic [W-1:0] FP_INIT = 32'd200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [W-1:0]  cmd_target,
  input  logic [LW-1:0] cmd_locals,
  output logic          busy,
  output logic          done,
  output logic [W-1:0]  ip_o,
  output logic [W-1:0]  sp_o,
  output logic [W-1:0]  fp_o,
  output logic          mem_en,
  output logic          mem_we,
  output logic [W-1:0]  mem_addr,
  output logic [W-1:0]  mem_wdata,
  input  logic [W-1:0]  mem_rdata
);
  fs_step_e step;
  logic     accept;
  logic     pop_to_ip;

  fs_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .step      (step),
    .accept    (accept),
    .pop_to_ip (pop_to_ip),
    .busy      (busy),
    .done      (done)
  );

  fs_regs #(
    .W(W), .LW(LW), .IP_INIT(IP_INIT), .SP_INIT(SP_INIT), .FP_INIT(FP_INIT)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (step),
    .accept     (accept),
    .pop_to_ip  (pop_to_ip),
    .cmd_target (cmd_target),
    .cmd_locals (cmd_locals),
    .mem_rdata  (mem_rdata),
    .ip         (ip_o),
    .sp         (sp_o),
    .fp         (fp_o),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata)
  );
endmodule

// File: rtl/fs_checker.sv
module fs_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_valid,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] ip_o,
  input logic [W-1:0] sp_o,
  input logic [W-1:0] fp_o,
  input logic         mem_en,
  input logic         mem_we,
  input logic [W-1:0] mem_addr
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmd_valid) |=> (!busy && $stable(ip_o) && $stable(sp_o) && $stable(fp_o)));

  a_r7_push_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_en && mem_addr == sp_o - ONE));

  a_r7_push_sp: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (sp_o == $past(sp_o) - ONE));

  a_r7_pop_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |-> (mem_addr == sp_o));

  a_r7_pop_sp: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |=> (sp_o == $past(sp_o) + ONE));

  a_r1_idle_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_en);
endmodule

bind frame_seq fs_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .busy      (busy),
  .done      (done),
  .ip_o      (ip_o),
  .sp_o      (sp_o),
  .fp_o      (fp_o),
  .mem_en    (mem_en),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr)
);

// File: tb/sim_frame_seq.sv
module sim_frame_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] IP0 = 32'h0000_1000;
  localparam logic [31:0] SP0 = 32'd200;
  localparam logic [31:0] FP0 = 32'd200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [31:0] cmd_target = '0;
  logic [15:0] cmd_locals = '0;
  logic        busy, done, mem_en, mem_we;
  logic [31:0] ip_o, sp_o, fp_o, mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;

  logic [31:0] mem [256];
  int          wcnt;
  logic [31:0] wa [4];
  logic [31:0] wd [4];

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] e_ip, e_sp, e_fp;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_seq u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_target(cmd_target), .cmd_locals(cmd_locals), .busy(busy), .done(done),
    .ip_o(ip_o), .sp_o(sp_o), .fp_o(fp_o), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        mem[mem_addr[7:0]] <= mem_wdata;
        if (wcnt < 4) begin
          wa[wcnt] <= mem_addr;
          wd[wcnt] <= mem_wdata;
        end
        wcnt <= wcnt + 1;
      end else begin
        mem_rdata <= mem[mem_addr[7:0]];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_regs(input string req);
    chk(ip_o == e_ip, {req, " ip"}, ip_o, e_ip);
    chk(sp_o == e_sp, {req, " sp"}, sp_o, e_sp);
    chk(fp_o == e_fp, {req, " fp"}, fp_o, e_fp);
  endtask

  // Offer a command at a falling edge; count rising edges until done is seen.
  task automatic run(input logic [1:0] op, input logic [31:0] tgt, input logic [15:0] loc,
                     input bit intrude, output int lat);
    wcnt = 0;
    cmd_op = op; cmd_target = tgt; cmd_locals = loc; cmd_valid = 1'b1;
    lat = 0;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); @(negedge clk);
      lat++;
      if (lat == 1) begin
        cmd_valid = intrude;
        cmd_op = 2'd0; cmd_target = 32'hDEAD_BEEF;
      end else begin
        cmd_valid = 1'b0;
      end
      if (done) break;
    end
    cmd_valid = 1'b0;
    if (!done) lat = -1;
  endtask

  task automatic t_reset;
    chk(ip_o == IP0 && sp_o == SP0 && fp_o == FP0, "R1 regs", ip_o, IP0);
    chk(!busy && !done && !mem_en, "R1 idle pins", {busy, done, mem_en}, 0);
  endtask

  task automatic t_call(input logic [31:0] tgt);
    int lat;
    logic [31:0] sp_b = e_sp, ip_b = e_ip;
    run(2'd0, tgt, 16'd0, 1'b0, lat);
    e_sp = sp_b - 1; e_ip = tgt;
    chk(lat == 2, "R2 latency", lat, 2);
    chk_regs("R2");
    chk(wcnt == 1 && wa[0] == sp_b - 1 && wd[0] == ip_b, "R2 push", wd[0], ip_b);
    chk(!busy, "R9 busy low at done", busy, 0);
  endtask

  task automatic t_enter(input logic [15:0] loc, input bit intrude, input string req);
    int lat;
    logic [31:0] sp_b = e_sp, fp_b = e_fp;
    run(2'd1, 32'h0, loc, intrude, lat);
    e_fp = sp_b - 1; e_sp = sp_b - 1 - {16'd0, loc};
    chk(lat == 3, {req, " R3 latency"}, lat, 3);
    chk_regs({req, " R3"});
    chk(wcnt == 1 && wa[0] == sp_b - 1 && wd[0] == fp_b, {req, " R3 push fp"}, wd[0], fp_b);
  endtask

  task automatic t_leave;
    int lat;
    logic [31:0] fp_b = e_fp;
    run(2'd2, 32'h0, 16'd0, 1'b0, lat);
    e_fp = mem[fp_b[7:0]]; e_sp = fp_b + 1;
    chk(lat == 4, "R5 latency", lat, 4);
    chk_regs("R5");
    chk(wcnt == 0, "R7 no write on pop", wcnt, 0);
  endtask

  task automatic t_ret;
    int lat;
    logic [31:0] sp_b = e_sp;
    run(2'd3, 32'h0, 16'd0, 1'b0, lat);
    e_ip = mem[sp_b[7:0]]; e_sp = sp_b + 1;
    chk(lat == 3, "R6 latency", lat, 3);
    chk_regs("R6");
  endtask

  task automatic t_frame_order;
    chk(mem[8'd199] == IP0, "R10 return point at sp-1", mem[8'd199], IP0);
    chk(mem[8'd198] == FP0, "R10 saved fp at sp-2", mem[8'd198], FP0);
  endtask

  task automatic t_done_pulse;
    @(posedge clk); @(negedge clk);
    chk(!done, "R9 done single cycle", done, 0);
    chk_regs("R9 regs hold");
  endtask

  initial begin
    e_ip = IP0; e_sp = SP0; e_fp = FP0; wcnt = 0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_call(32'h0000_2000);
    t_done_pulse();
    t_enter(16'd5, 1'b0, "main");
    t_frame_order();
    t_leave();
    t_ret();
    chk(ip_o == IP0 && sp_o == SP0 && fp_o == FP0, "R11 round trip", sp_o, SP0);
    t_enter(16'd0, 1'b0, "R4 zero");
    chk(sp_o == fp_o, "R4 zero locals sp==fp", sp_o, fp_o);
    t_enter(16'hFFFF, 1'b0, "R4 max");
    chk(sp_o == 32'd198 - 32'd65535, "R4 max wrap", sp_o, 32'd198 - 32'd65535);
    t_leave();
    t_leave();
    chk(sp_o == SP0 && fp_o == FP0, "R5 double exit", fp_o, FP0);
    t_enter(16'd3, 1'b1, "R8 intrusion");
    chk(ip_o == IP0, "R8 ignored call left ip", ip_o, IP0);
    t_leave();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule